// File: doc/BRIEF.md
# Descriptor-Driven DMA Service Sequencer

This block is the control core of a multi-channel DMA engine that serves hardware transfer requests one channel at a time. Each channel owns a small descriptor held in an external descriptor RAM. A descriptor has four words: part A holds the source and destination addresses, part B holds a signed address step and a remaining-transfer count, word 2 is unused and word 3 is a link word. A request is latched per channel. Among the latched requests, the lowest channel number wins. The winner's descriptor is fetched in two reads. The block then moves one data word from the source address to the destination address over a simple bus with a ready handshake, reads the link word, and writes the updated descriptor back in two writes.

The second write-back cycle is also the arbitration cycle for the next service. Back-to-back services therefore start a fixed 9 cycles apart, and each bus wait state adds one cycle. When a descriptor's count reaches zero, the channel's done flag is raised and its request enable is dropped. A valid link word injects a request for another channel, and that request takes part in the overlapped arbitration.

The controller is a single state machine with these states:
- IDLE: arbitrates, and moves to FETCH_A when any request is latched.
- FETCH_A, then FETCH_B: the two descriptor reads.
- CALC: the address step is applied.
- ARM: the count is decremented.
- READ: waits for ready, then moves to WRITE.
- WRITE: waits for ready, then moves to LINK.
- LINK, then WB_A, then WB_B: link check and the two write-backs.
- WB_B: arbitrates and moves to FETCH_A if a request is latched, otherwise to IDLE.

Top module: `dma_svc_seq`

## Requirements
- R1: After reset, all done flags and all enables are 0, no request is latched, and bus_req, desc_rd and desc_we are low.
- R2: Arbitration grants the lowest-numbered channel with a latched request. A request stays latched until its channel is granted.
- R3: A hw_req pulse is latched only if the channel's enable is already set. A pulse on en_set sets the enable and clears the done flag for that channel.
- R4: A service begins with a read of descriptor word 0 (part A: source address in bits 31:16, destination address in bits 15:0). Word 1 (part B: signed step in bits 31:24, count in bits 15:0) is read in the next cycle. The descriptor address is {channel, word[1:0]}.
- R5: One bus read is made at the source address, then one bus write of the read data to the destination address.
- R6: While bus_req is high and bus_rdy is low, bus_req, bus_we, bus_addr and bus_wdata hold their values.
- R7: After the bus write, word 3 is read. If bit 31 is set, the channel in bits 1:0 gets a latched request whether or not it is enabled.
- R8: Word 0 is written back as {source+step, destination+step}. In the next cycle, word 1 is written back as {step, 8'h00, count-1}.
- R9: When count-1 is zero, the channel's done flag sets and its enable clears.
- R10: With a request pending, the next service's word-0 read comes in the cycle right after the word-1 write-back. Services start 9 + read waits + write waits cycles apart.
- R11: The step is a two's-complement value, so a negative step lowers both addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | NCH | Per-channel request pulses |
| en_set | input | NCH | Per-channel enable set (also clears done) |
| done | output | NCH | Per-channel completion flags |
| desc_rd | output | 1 | Descriptor RAM read strobe |
| desc_we | output | 1 | Descriptor RAM write strobe |
| desc_addr | output | CW+2 | Descriptor word address {channel, word} |
| desc_wdata | output | 2*AW | Descriptor write data |
| desc_rdata | input | 2*AW | Descriptor read data, valid in the same cycle |
| bus_req | output | 1 | Bus access active |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, taken when bus_rdy is high |
| bus_rdy | input | 1 | Bus ready; each low cycle is one wait state |

## Verification
Two things share one cycle: the part-B write-back of the finishing channel and the arbitration that picks the next one. The bench provokes this by latching two requests at once, or by letting a link word inject the second request. It then sweeps read and write wait states from 0 to 2 each. In every case it checks three things: the descriptor writes land in consecutive cycles, the next word-0 fetch comes in the very next cycle, and fetch starts are exactly 9 + waits apart. It also checks that the written descriptor words match the arithmetic expected values.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_A,
        S_FETCH_B,
        S_CALC,
        S_ARM,
        S_READ,
        S_WRITE,
        S_LINK,
        S_WB_A,
        S_WB_B
    } svc_state_t;

    localparam logic [1:0] WORD_PART_A = 2'd0;
    localparam logic [1:0] WORD_PART_B = 2'd1;
    localparam logic [1:0] WORD_LINK   = 2'd3;

endpackage

// File: rtl/dsq_arbiter.sv
module dsq_arbiter #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] grant,
    output logic [CW-1:0]  win_idx,
    output logic           any_req
);

    logic [NCH:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_prio
        assign grant[i]       = req[i] & ~blocked[i];
        assign blocked[i + 1] = blocked[i] | req[i];
    end

    assign any_req = blocked[NCH];

    always_comb begin
        win_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = CW'(i);
            end
        end
    end

endmodule

// File: rtl/dsq_chan_flags.sv
module dsq_chan_flags #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] en_set,
    input  logic [NCH-1:0] link_set,
    input  logic [NCH-1:0] grant_clr,
    input  logic [NCH-1:0] done_evt,
    output logic [NCH-1:0] pending,
    output logic [NCH-1:0] done
);

    logic [NCH-1:0] enable;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending[c] <= 1'b0;
                enable[c]  <= 1'b0;
                done[c]    <= 1'b0;
            end else begin
                pending[c] <= (pending[c] & ~grant_clr[c])
                            | (hw_req[c] & enable[c])
                            | link_set[c];
                if (en_set[c]) begin
                    enable[c] <= 1'b1;
                    done[c]   <= 1'b0;
                end else if (done_evt[c]) begin
                    enable[c] <= 1'b0;
                    done[c]   <= 1'b1;
                end
            end
        end

        // R2: a latched request survives until its channel is granted
        a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
            pending[c] && !grant_clr[c] |=> pending[c]);

        // R9: completion raises done and drops the enable
        a_r9_done_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
            done_evt[c] && !en_set[c] |=> done[c] && !enable[c]);

        // R3: enable set clears done
        a_r3_enable_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
            en_set[c] |=> !done[c] && enable[c]);
    end

endmodule

// File: rtl/dsq_desc_calc.sv
module dsq_desc_calc #(
    parameter int AW = 16,
    parameter int OW = 8
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [OW-1:0] step,
    input  logic [AW-1:0] cnt,
    output logic [AW-1:0] src_nx,
    output logic [AW-1:0] dst_nx,
    output logic [AW-1:0] cnt_nx,
    output logic          last
);

    logic [AW-1:0] step_ext;

    assign step_ext = {{(AW - OW){step[OW-1]}}, step};
    assign src_nx   = src + step_ext;
    assign dst_nx   = dst + step_ext;
    assign cnt_nx   = cnt - AW'(1);
    assign last     = (cnt_nx == '0);

endmodule

// File: rtl/dma_svc_seq.sv
module dma_svc_seq
    import dsq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int OW  = 8,
    localparam int CW  = $clog2(NCH),
    localparam int ADW = CW + 2,
    localparam int DSW = 2 * AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] en_set,
    output logic [NCH-1:0] done,
    output logic           desc_rd,
    output logic           desc_we,
    output logic [ADW-1:0] desc_addr,
    output logic [DSW-1:0] desc_wdata,
    input  logic [DSW-1:0] desc_rdata,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_rdy
);

    svc_state_t state, state_nx;

    logic [NCH-1:0] pending, grant, grant_clr, link_set, done_evt;
    logic [CW-1:0]  win_idx, cur_ch;
    logic           any_req, arb_slot;

    logic [AW-1:0]  src_q, dst_q, cnt_q, src_nq, dst_nq, cnt_nq;
    logic [OW-1:0]  step_q;
    logic [DW-1:0]  data_q;
    logic           last_q;
    logic [AW-1:0]  src_c, dst_c, cnt_c;
    logic           last_c;
    logic [1:0]     word_sel;

    dsq_arbiter #(.NCH(NCH)) u_arb (
        .req     (pending),
        .grant   (grant),
        .win_idx (win_idx),
        .any_req (any_req)
    );

    dsq_chan_flags #(.NCH(NCH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_req    (hw_req),
        .en_set    (en_set),
        .link_set  (link_set),
        .grant_clr (grant_clr),
        .done_evt  (done_evt),
        .pending   (pending),
        .done      (done)
    );

    dsq_desc_calc #(.AW(AW), .OW(OW)) u_calc (
        .src    (src_q),
        .dst    (dst_q),
        .step   (step_q),
        .cnt    (cnt_q),
        .src_nx (src_c),
        .dst_nx (dst_c),
        .cnt_nx (cnt_c),
        .last   (last_c)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (any_req) state_nx = S_FETCH_A;
            S_FETCH_A: state_nx = S_FETCH_B;
            S_FETCH_B: state_nx = S_CALC;
            S_CALC:    state_nx = S_ARM;
            S_ARM:     state_nx = S_READ;
            S_READ:    if (bus_rdy) state_nx = S_WRITE;
            S_WRITE:   if (bus_rdy) state_nx = S_LINK;
            S_LINK:    state_nx = S_WB_A;
            S_WB_A:    state_nx = S_WB_B;
            S_WB_B:    state_nx = any_req ? S_FETCH_A : S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        desc_rd    = 1'b0;
        desc_we    = 1'b0;
        word_sel   = WORD_PART_A;
        desc_wdata = '0;
        bus_req    = 1'b0;
        bus_we     = 1'b0;
        bus_addr   = src_q;
        arb_slot   = 1'b0;
        link_set   = '0;
        done_evt   = '0;
        unique case (state)
            S_IDLE:    arb_slot = 1'b1;
            S_FETCH_A: begin
                desc_rd  = 1'b1;
                word_sel = WORD_PART_A;
            end
            S_FETCH_B: begin
                desc_rd  = 1'b1;
                word_sel = WORD_PART_B;
            end
            S_CALC, S_ARM: ;
            S_READ:    bus_req = 1'b1;
            S_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dst_q;
            end
            S_LINK: begin
                desc_rd  = 1'b1;
                word_sel = WORD_LINK;
                if (desc_rdata[DSW-1]) begin
                    link_set = NCH'(1) << desc_rdata[CW-1:0];
                end
            end
            S_WB_A: begin
                desc_we    = 1'b1;
                word_sel   = WORD_PART_A;
                desc_wdata = {src_nq, dst_nq};
            end
            S_WB_B: begin
                desc_we    = 1'b1;
                word_sel   = WORD_PART_B;
                desc_wdata = {step_q, {(AW - OW){1'b0}}, cnt_nq};
                arb_slot   = 1'b1;
                if (last_q) begin
                    done_evt = NCH'(1) << cur_ch;
                end
            end
            default: ;
        endcase
    end

    assign desc_addr = {cur_ch, word_sel};
    assign bus_wdata = data_q;
    assign grant_clr = arb_slot ? grant : '0;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            step_q <= '0;
            cnt_q  <= '0;
            src_nq <= '0;
            dst_nq <= '0;
            cnt_nq <= '0;
            last_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (arb_slot && any_req) begin
                cur_ch <= win_idx;
            end
            if (state == S_FETCH_A) begin
                src_q <= desc_rdata[DSW-1:AW];
                dst_q <= desc_rdata[AW-1:0];
            end
            if (state == S_FETCH_B) begin
                step_q <= desc_rdata[DSW-1:DSW-OW];
                cnt_q  <= desc_rdata[AW-1:0];
            end
            if (state == S_CALC) begin
                src_nq <= src_c;
                dst_nq <= dst_c;
            end
            if (state == S_ARM) begin
                cnt_nq <= cnt_c;
                last_q <= last_c;
            end
            if (state == S_READ && bus_rdy) begin
                data_q <= bus_rdata;
            end
        end
    end

    // R1: no bus or descriptor activity while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !bus_req && !desc_rd && !desc_we);

    // R2: at most one channel granted
    a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_clr));

    // R4: part A read is followed by part B read of the same channel
    a_r4_fetch_pair: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd && desc_addr[1:0] == WORD_PART_A |=>
        desc_rd && desc_addr[1:0] == WORD_PART_B && $stable(desc_addr[ADW-1:2]));

    // R6: bus phase held while ready is low
    a_r6_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=>
        bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    // R8: the two write-backs are back to back for one channel
    a_r8_wb_pair: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we && desc_addr[1:0] == WORD_PART_A |=>
        desc_we && desc_addr[1:0] == WORD_PART_B && $stable(desc_addr[ADW-1:2]));

    // R10: a pending request is fetched right after the last write-back
    a_r10_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we && desc_addr[1:0] == WORD_PART_B && (|pending) |=>
        desc_rd && desc_addr[1:0] == WORD_PART_A);

endmodule

// File: tb/dma_svc_seq_test.sv
module dma_svc_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int ADW = 4;
    localparam int DSW = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] hw_req, en_set, done;
    logic           desc_rd, desc_we;
    logic [ADW-1:0] desc_addr;
    logic [DSW-1:0] desc_wdata, desc_rdata;
    logic           bus_req, bus_we, bus_rdy;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata, bus_rdata;

    dma_svc_seq uut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .en_set(en_set), .done(done),
        .desc_rd(desc_rd), .desc_we(desc_we), .desc_addr(desc_addr),
        .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Descriptor RAM model, loaded by the bench through tb_* strobes
    logic [DSW-1:0] mem [16];
    logic           tb_we = 1'b0;
    logic [ADW-1:0] tb_a = '0;
    logic [DSW-1:0] tb_d = '0;
    assign desc_rdata = mem[desc_addr];
    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (desc_we) mem[desc_addr] <= desc_wdata;
    end

    // Bus slave with programmable wait states
    int rws = 0, wws = 0, wcnt = 0;
    assign bus_rdata = {bus_addr, ~bus_addr};
    assign bus_rdy   = bus_req && (wcnt == (bus_we ? wws : rws));
    always @(posedge clk) begin
        if (bus_req && !bus_rdy) wcnt <= wcnt + 1;
        else wcnt <= 0;
    end

    // Event monitor
    logic log_clr = 1'b0;
    int cyc = 0, nfa = 0, nfb = 0, nwba = 0, nwbb = 0, nwr = 0;
    int fa_cyc [16], fb_cyc [16], wba_cyc [16], wbb_cyc [16];
    int fa_ch [16];
    logic [AW-1:0] wr_a [16];
    logic [DW-1:0] wr_d [16];
    int schk = 0, sfail = 0;
    logic hold_v = 1'b0, hold_we;
    logic [AW-1:0] hold_a;
    logic [DW-1:0] hold_d;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (log_clr) begin
            nfa = 0; nfb = 0; nwba = 0; nwbb = 0; nwr = 0;
        end else begin
            if (desc_rd && desc_addr[1:0] == 2'd0 && nfa < 16) begin
                fa_cyc[nfa] = cyc; fa_ch[nfa] = int'(desc_addr[3:2]); nfa = nfa + 1;
            end
            if (desc_rd && desc_addr[1:0] == 2'd1 && nfb < 16) begin
                fb_cyc[nfb] = cyc; nfb = nfb + 1;
            end
            if (desc_we && desc_addr[1:0] == 2'd0 && nwba < 16) begin
                wba_cyc[nwba] = cyc; nwba = nwba + 1;
            end
            if (desc_we && desc_addr[1:0] == 2'd1 && nwbb < 16) begin
                wbb_cyc[nwbb] = cyc; nwbb = nwbb + 1;
            end
            if (bus_req && bus_we && bus_rdy && nwr < 16) begin
                wr_a[nwr] = bus_addr; wr_d[nwr] = bus_wdata; nwr = nwr + 1;
            end
        end
        if (hold_v && rst_n) begin
            schk = schk + 1;
            if (!bus_req || bus_we !== hold_we || bus_addr !== hold_a || bus_wdata !== hold_d) begin
                sfail = sfail + 1;
                $display("FAIL R6 bus phase changed during wait: act=%h/%h exp=%h/%h",
                         bus_addr, bus_wdata, hold_a, hold_d);
            end
        end
        hold_v  = rst_n && bus_req && !bus_rdy;
        hold_we = bus_we; hold_a = bus_addr; hold_d = bus_wdata;
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hw_req = '0; en_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_word(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = ADW'(a); tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic set_desc(input int ch, input logic [15:0] sa, input logic [15:0] da,
                            input logic [7:0] stp, input logic [15:0] cnt, input logic [31:0] lnk);
        put_word(ch * 4 + 0, {sa, da});
        put_word(ch * 4 + 1, {stp, 8'h00, cnt});
        put_word(ch * 4 + 2, 32'h0);
        put_word(ch * 4 + 3, lnk);
    endtask

    task automatic pulse_en(input logic [NCH-1:0] m);
        @(negedge clk); en_set = m;
        @(negedge clk); en_set = '0;
    endtask

    task automatic pulse_req(input logic [NCH-1:0] m);
        @(negedge clk); hw_req = m;
        @(negedge clk); hw_req = '0;
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    // Two channels back to back under one wait-state setting
    task automatic run_pair(input int r, input int w);
        logic [15:0] sa1, da1, sa2, da2;
        rws = r; wws = w;
        sa1 = 16'h1000 + 16'(r * 16 + w);
        da1 = 16'h2000 + 16'(w * 16 + r);
        sa2 = 16'h3000 + 16'(r);
        da2 = 16'h4000 + 16'(w);
        do_reset();
        set_desc(1, sa1, da1, 8'h04, 16'd1, 32'h0);
        set_desc(2, sa2, da2, 8'hFE, 16'd2, 32'h0);
        pulse_en(4'b0110);
        clear_log();
        pulse_req(4'b0110);
        repeat (60) @(negedge clk);
        chk("R2 service count", 32'(nfa), 32'd2);
        chk("R2 first winner", 32'(fa_ch[0]), 32'd1);
        chk("R2 second winner", 32'(fa_ch[1]), 32'd2);
        chk("R4 part B follows part A", 32'(fb_cyc[0]), 32'(fa_cyc[0] + 1));
        chk("R10 service period", 32'(fa_cyc[1] - fa_cyc[0]), 32'(9 + r + w));
        chk("R8 write-backs consecutive", 32'(wbb_cyc[0]), 32'(wba_cyc[0] + 1));
        chk("R10 fetch follows part-B write-back", 32'(fa_cyc[1]), 32'(wbb_cyc[0] + 1));
        chk("R5 write count", 32'(nwr), 32'd2);
        chk("R5 first write address", 32'(wr_a[0]), 32'(da1));
        chk("R5 first write data", wr_d[0], {sa1, ~sa1});
        chk("R5 second write address", 32'(wr_a[1]), 32'(da2));
        chk("R5 second write data", wr_d[1], {sa2, ~sa2});
        chk("R8 part A ch1", mem[4], {sa1 + 16'd4, da1 + 16'd4});
        chk("R8 part B ch1", mem[5], {8'h04, 8'h00, 16'd0});
        chk("R11 part A ch2 negative step", mem[8], {sa2 - 16'd2, da2 - 16'd2});
        chk("R8 part B ch2", mem[9], {8'hFE, 8'h00, 16'd1});
        chk("R9 done flags", 32'(done), 32'b0010);
    endtask

    initial begin
        rst_n = 1'b0;
        hw_req = '0;
        en_set = '0;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 bus idle after reset", {29'd0, bus_req, desc_rd, desc_we}, 32'd0);

        // Sweep read and write wait states
        for (int r = 0; r < 3; r++) begin
            for (int w = 0; w < 3; w++) begin
                run_pair(r, w);
            end
        end

        // R2: priority among simultaneous requests and latching of a late one
        rws = 0; wws = 0;
        do_reset();
        for (int c = 0; c < NCH; c++) begin
            set_desc(c, 16'h0100 * 16'(c + 1), 16'h0800 + 16'(c), 8'h01, 16'd5, 32'h0);
        end
        pulse_en(4'b1111);
        clear_log();
        pulse_req(4'b1101);
        repeat (3) @(negedge clk);
        pulse_req(4'b0010);
        repeat (80) @(negedge clk);
        chk("R2 four services", 32'(nfa), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R2 grant order", 32'(fa_ch[k]), 32'(k));
        end
        chk("R9 no done with count left", 32'(done), 32'd0);

        // R3 and R9: enable gating, completion, re-enable
        do_reset();
        set_desc(1, 16'h5000, 16'h6000, 8'h02, 16'd1, 32'h0);
        clear_log();
        pulse_req(4'b0010);
        repeat (40) @(negedge clk);
        chk("R3 disabled request ignored (fetch)", 32'(nfa), 32'd0);
        chk("R3 disabled request ignored (bus)", 32'(nwr), 32'd0);
        pulse_en(4'b0010);
        pulse_req(4'b0010);
        repeat (40) @(negedge clk);
        chk("R3 enabled request served", 32'(nfa), 32'd1);
        chk("R9 done set at zero count", 32'(done), 32'b0010);
        clear_log();
        pulse_req(4'b0010);
        repeat (40) @(negedge clk);
        chk("R9 enable cleared after done", 32'(nfa), 32'd0);
        chk("R9 done held", 32'(done), 32'b0010);
        pulse_en(4'b0010);
        @(negedge clk);
        chk("R3 enable set clears done", 32'(done), 32'd0);

        // R7: link word injects a request for a disabled channel
        do_reset();
        set_desc(0, 16'h0A00, 16'h0B00, 8'h01, 16'd3, 32'h8000_0003);
        set_desc(3, 16'h0C00, 16'h0D00, 8'h01, 16'd3, 32'h0);
        pulse_en(4'b0001);
        clear_log();
        pulse_req(4'b0001);
        repeat (60) @(negedge clk);
        chk("R7 linked channel served", 32'(nfa), 32'd2);
        chk("R7 linked channel id", 32'(fa_ch[1]), 32'd3);
        chk("R7 link overlap period", 32'(fa_cyc[1] - fa_cyc[0]), 32'd9);
        chk("R7 linked write address", 32'(wr_a[1]), 32'h0D00);

        $display("== %0d vectors applied, %0d miscompares ==", nchk + schk, nfail + sfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + schk + 1, nfail + sfail + 1);
        $finish;
    end

endmodule